// File: doc/BRIEF.md
# Reconfigurable Lattice Cell

This block is one tile of a two-dimensional reconfigurable fabric. It exchanges tokens with four neighbours (above, below, left, right) over two-wire dual-rail links, one input and one output per side. On every link the code 00 means no token, 01 carries a logic 0 and 10 carries a logic 1. The code 11 is illegal: on an input it counts as no token, and the cell never drives it on an output. The data path is combinational apart from a per-lane decision latch. No clock drives it.

A three-bit type word selects one of eight behaviours: blank, crossing, horizontal wire, vertical wire, and four comparing types. The word is shifted in serially on the configuration clock while the cell is frozen. The serial output repeats the serial input three edges later, so cells can be daisy-chained. A comparing cell passes vertical tokens straight through. It forwards a horizontal token only as a 1 when its comparison succeeds, and as a 0 otherwise. The comparison result is captured when the lane token arrives and is held until that lane returns to no token. Each side has an input flag saying that the neighbour there is unused. The cell reports two flags of its own, saying whether it leaves its horizontal lanes or its vertical lanes unused.

Top module: `lattice_cell`

## Requirements
- R1: Link code 00 is no token, 01 is logic 0, 10 is logic 1. An input of 11 is handled exactly as 00, and no output ever carries 11.
- R2: While rst_n is low, each rising edge of clk_cfg shifts cfg_si into the type word, first bit into the most significant position. After three edges the word is the type: 000 blank, 001 crossing, 010 horizontal wire, 011 vertical wire, 100 compare-one, 101 compare-zero, 110 always-pass, 111 pass-if-present.
- R3: While frozen, cfg_so shows the cfg_si bit captured on the third most recent clk_cfg edge, with the current edge counted as one of the three.
- R4: While rst_n is high, clk_cfg edges change neither the type word nor cfg_so.
- R5: While rst_n is low, all four data outputs are 00 whatever the inputs.
- R6: h_void is 1 exactly for blank and vertical wire. v_void is 1 exactly for blank and horizontal wire. Both depend on the type alone.
- R7: A blank cell drives 00 on all four data outputs for any inputs.
- R8: Crossing: up_o follows dn_i, dn_o follows up_i, rt_o follows lf_i and lf_o follows rt_i. A horizontal wire does only the last two and drives 00 upward and downward. A vertical wire does only the first two and drives 00 sideways.
- R9: A comparing cell (types 100 to 111) passes vertically as a crossing does. rt_o is 00 when lf_i is empty. It is 10 when lf_i is 1 and the rightward decision holds, and 01 otherwise. lf_o is formed from rt_i and the leftward decision in the same way.
- R10: The decision is computed from the token on dn_i. Compare-one succeeds on a 1, compare-zero on a 0, always-pass on anything including no token, and pass-if-present on any 0 or 1.
- R11: A lane's decision follows dn_i while that lane's input is empty, and is frozen from the moment a token arrives on it until it returns to empty. The token on dn_i must be settled before the lane token arrives.
- R12: When a side's neighbour-unused flag is 1, the output on that side is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Freeze, active low; enables configuration shifting |
| cfg_si | input | 1 | Serial configuration input |
| cfg_so | output | 1 | Serial configuration output, three edges behind cfg_si |
| nbr_void_u | input | 1 | Neighbour above is unused |
| nbr_void_d | input | 1 | Neighbour below is unused |
| nbr_void_l | input | 1 | Neighbour on the left is unused |
| nbr_void_r | input | 1 | Neighbour on the right is unused |
| up_i | input | 2 | Token from the neighbour above |
| up_o | output | 2 | Token to the neighbour above |
| dn_i | input | 2 | Token from the neighbour below |
| dn_o | output | 2 | Token to the neighbour below |
| lf_i | input | 2 | Token from the left neighbour |
| lf_o | output | 2 | Token to the left neighbour |
| rt_i | input | 2 | Token from the right neighbour |
| rt_o | output | 2 | Token to the right neighbour |
| h_void | output | 1 | Cell leaves its horizontal lanes unused |
| v_void | output | 1 | Cell leaves its vertical lanes unused |

## Verification
A wrong type word shows up at once after release, both on h_void and v_void and as wrong routing on the first token applied. A slip in the shift chain shows on cfg_so within three configuration edges. A decision latch that is transparent when it should hold only shows when dn_i changes while a lane token is present. The bench therefore changes the vertical token between lane arrivals and also in the middle of them, and checks the sideways output in the same step. An illegal 11 code or a neighbour mask error is visible on the affected output as soon as the input settles.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int RAIL_W = 2;
  localparam int KIND_W = 3;

  typedef logic [RAIL_W-1:0] rail_t;

  localparam rail_t RAIL_NONE = 2'b00;
  localparam rail_t RAIL_ZERO = 2'b01;
  localparam rail_t RAIL_ONE  = 2'b10;

  typedef enum logic [KIND_W-1:0] {
    K_BLANK = 3'd0,
    K_CROSS = 3'd1,
    K_HWIRE = 3'd2,
    K_VWIRE = 3'd3,
    K_HIT1  = 3'd4,
    K_HIT0  = 3'd5,
    K_ANY   = 3'd6,
    K_SEEN  = 3'd7
  } kind_e;

  // Illegal 11 collapses to no token.
  function automatic rail_t rail_clean(rail_t r);
    return (r == 2'b11) ? RAIL_NONE : r;
  endfunction

  // Comparison of the vertical token for the comparing cell types.
  function automatic logic kind_passes(kind_e k, rail_t v);
    logic ok;
    case (k)
      K_HIT1:  ok = (v == RAIL_ONE);
      K_HIT0:  ok = (v == RAIL_ZERO);
      K_ANY:   ok = 1'b1;
      K_SEEN:  ok = (v != RAIL_NONE);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Lane token combined with the held decision.
  function automatic rail_t rail_gate(rail_t lane, logic ok);
    rail_t r;
    if (lane == RAIL_NONE)                 r = RAIL_NONE;
    else if (ok && (lane == RAIL_ONE))     r = RAIL_ONE;
    else                                   r = RAIL_ZERO;
    return r;
  endfunction
endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int LEN = lcell_pkg::KIND_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           si,
  output logic           so,
  output logic [LEN-1:0] word
);
  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;
  logic           shift_en;

  // Shifting is allowed only while the cell is frozen.
  assign shift_en = ~rst_n;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {sh_q[LEN-2:0], si};
  end

  always_ff @(posedge clk) begin
    sh_q <= sh_d;
  end

  assign so   = sh_q[LEN-1];
  assign word = sh_q;

  // R4: configuration is held once the cell runs
  a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(sh_q));

  generate
    if (LEN == 3) begin : g_delay_chk
      // R3: serial output lags the serial input by three edges
      a_r3_so_delay: assert property (@(posedge clk)
        ($past(!rst_n, 1) && $past(!rst_n, 2) && $past(!rst_n, 3))
        |-> (so == $past(si, 3)));
    end
  endgenerate
endmodule

// File: rtl/lcell_lane_hold.sv
module lcell_lane_hold
  import lcell_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  kind_e kind,
  input  rail_t vert,
  input  rail_t lane,
  output logic  pass_o
);
  logic lane_idle;
  logic pass_q;

  assign lane_idle = (lane == RAIL_NONE);

  // Transparent while the lane is empty, opaque while a token occupies it.
  always_latch begin
    if (lane_idle) pass_q = kind_passes(kind, vert);
  end

  assign pass_o = pass_q;

  // R11: decision does not move while the lane stays occupied
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane != RAIL_NONE) && ($past(lane) != RAIL_NONE)) |-> $stable(pass_q));
endmodule

// File: rtl/lcell_route.sv
module lcell_route
  import lcell_pkg::*;
(
  input  kind_e       kind,
  input  logic        frozen,
  input  logic [3:0]  nbr_void,
  input  rail_t       up_c,
  input  rail_t       dn_c,
  input  rail_t       lf_c,
  input  rail_t       rt_c,
  input  logic        pass_r,
  input  logic        pass_l,
  output rail_t       up_o,
  output rail_t       dn_o,
  output rail_t       lf_o,
  output rail_t       rt_o,
  output logic        h_void,
  output logic        v_void
);
  localparam int SIDES  = 4;
  localparam int SIDE_U = 3;
  localparam int SIDE_D = 2;
  localparam int SIDE_L = 1;
  localparam int SIDE_R = 0;

  logic vert_on;
  logic horz_on;
  logic horz_gate;
  logic [SIDES-1:0][RAIL_W-1:0] raw;
  logic [SIDES-1:0][RAIL_W-1:0] masked;

  always_comb begin
    vert_on   = 1'b0;
    horz_on   = 1'b0;
    horz_gate = 1'b0;
    case (kind)
      K_CROSS: begin vert_on = 1'b1; horz_on = 1'b1; end
      K_HWIRE: horz_on = 1'b1;
      K_VWIRE: vert_on = 1'b1;
      K_HIT1, K_HIT0, K_ANY, K_SEEN: begin vert_on = 1'b1; horz_gate = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    raw[SIDE_U] = vert_on ? dn_c : RAIL_NONE;
    raw[SIDE_D] = vert_on ? up_c : RAIL_NONE;
    if (horz_on) begin
      raw[SIDE_R] = lf_c;
      raw[SIDE_L] = rt_c;
    end else if (horz_gate) begin
      raw[SIDE_R] = rail_gate(lf_c, pass_r);
      raw[SIDE_L] = rail_gate(rt_c, pass_l);
    end else begin
      raw[SIDE_R] = RAIL_NONE;
      raw[SIDE_L] = RAIL_NONE;
    end
  end

  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_mask
      assign masked[s] = (frozen || nbr_void[s]) ? RAIL_NONE : raw[s];
    end
  endgenerate

  assign up_o = masked[SIDE_U];
  assign dn_o = masked[SIDE_D];
  assign lf_o = masked[SIDE_L];
  assign rt_o = masked[SIDE_R];

  assign h_void = (kind == K_BLANK) || (kind == K_VWIRE);
  assign v_void = (kind == K_BLANK) || (kind == K_HWIRE);
endmodule

// File: rtl/lattice_cell.sv
module lattice_cell
  import lcell_pkg::*;
(
  input  logic       clk_cfg,
  input  logic       rst_n,
  input  logic       cfg_si,
  output logic       cfg_so,
  input  logic       nbr_void_u,
  input  logic       nbr_void_d,
  input  logic       nbr_void_l,
  input  logic       nbr_void_r,
  input  logic [1:0] up_i,
  output logic [1:0] up_o,
  input  logic [1:0] dn_i,
  output logic [1:0] dn_o,
  input  logic [1:0] lf_i,
  output logic [1:0] lf_o,
  input  logic [1:0] rt_i,
  output logic [1:0] rt_o,
  output logic       h_void,
  output logic       v_void
);
  localparam int LANES = 2;

  logic [KIND_W-1:0] cfg_word;
  kind_e             kind;
  rail_t             up_c, dn_c, lf_c, rt_c;
  rail_t             lane_in [LANES];
  logic [LANES-1:0]  pass;

  lcell_cfg_chain #(.LEN(KIND_W)) u_cfg (
    .clk   (clk_cfg),
    .rst_n (rst_n),
    .si    (cfg_si),
    .so    (cfg_so),
    .word  (cfg_word)
  );

  assign kind = kind_e'(cfg_word);

  assign up_c = rail_clean(up_i);
  assign dn_c = rail_clean(dn_i);
  assign lf_c = rail_clean(lf_i);
  assign rt_c = rail_clean(rt_i);

  assign lane_in[0] = lf_c;
  assign lane_in[1] = rt_c;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_hold
      lcell_lane_hold u_hold (
        .clk    (clk_cfg),
        .rst_n  (rst_n),
        .kind   (kind),
        .vert   (dn_c),
        .lane   (lane_in[g]),
        .pass_o (pass[g])
      );
    end
  endgenerate

  lcell_route u_route (
    .kind     (kind),
    .frozen   (~rst_n),
    .nbr_void ({nbr_void_u, nbr_void_d, nbr_void_l, nbr_void_r}),
    .up_c     (up_c),
    .dn_c     (dn_c),
    .lf_c     (lf_c),
    .rt_c     (rt_c),
    .pass_r   (pass[0]),
    .pass_l   (pass[1]),
    .up_o     (up_o),
    .dn_o     (dn_o),
    .lf_o     (lf_o),
    .rt_o     (rt_o),
    .h_void   (h_void),
    .v_void   (v_void)
  );

  // R1: illegal code never leaves the cell
  a_r1_legal_out: assert property (@(posedge clk_cfg)
    (up_o != 2'b11) && (dn_o != 2'b11) && (lf_o != 2'b11) && (rt_o != 2'b11));

  // R5: frozen cell is silent
  a_r5_frozen_quiet: assert property (@(posedge clk_cfg)
    !rst_n |-> ((up_o == 2'b00) && (dn_o == 2'b00) && (lf_o == 2'b00) && (rt_o == 2'b00)));

  // R7: blank cell is silent
  a_r7_blank_quiet: assert property (@(posedge clk_cfg) disable iff (!rst_n)
    (kind == K_BLANK) |-> ((up_o | dn_o | lf_o | rt_o) == 2'b00));

  // R12: outputs toward unused neighbours are empty
  a_r12_nbr_mask: assert property (@(posedge clk_cfg)
    ((!nbr_void_u || up_o == 2'b00) && (!nbr_void_d || dn_o == 2'b00) &&
     (!nbr_void_l || lf_o == 2'b00) && (!nbr_void_r || rt_o == 2'b00)));

  // R9: comparing cells pass the upward token unchanged
  a_r9_vert_pass: assert property (@(posedge clk_cfg) disable iff (!rst_n)
    (cfg_word[2] && !nbr_void_u) |-> (up_o == rail_clean(dn_i)));
endmodule

// File: tb/tb_lattice_cell.sv
`timescale 1ns/1ps
module tb_lattice_cell;
  localparam logic [1:0] NO = 2'b00;
  localparam logic [1:0] ZE = 2'b01;
  localparam logic [1:0] ON = 2'b10;
  localparam logic [1:0] IL = 2'b11;

  logic       clk;
  logic       rst_n;
  logic       cfg_si;
  logic       cfg_so;
  logic       nv_u, nv_d, nv_l, nv_r;
  logic [1:0] up_i, dn_i, lf_i, rt_i;
  logic [1:0] up_o, dn_o, lf_o, rt_o;
  logic       h_void, v_void;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [2:0] kind_m;
  logic       dr_m, dl_m;

  lattice_cell dut (
    .clk_cfg(clk), .rst_n(rst_n), .cfg_si(cfg_si), .cfg_so(cfg_so),
    .nbr_void_u(nv_u), .nbr_void_d(nv_d), .nbr_void_l(nv_l), .nbr_void_r(nv_r),
    .up_i(up_i), .up_o(up_o), .dn_i(dn_i), .dn_o(dn_o),
    .lf_i(lf_i), .lf_o(lf_o), .rt_i(rt_i), .rt_o(rt_o),
    .h_void(h_void), .v_void(v_void)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cln(input logic [1:0] r);
    return (r == IL) ? NO : r;
  endfunction

  function automatic logic pred(input logic [2:0] k, input logic [1:0] v);
    case (k)
      3'd4: return v == ON;
      3'd5: return v == ZE;
      3'd6: return 1'b1;
      3'd7: return v != NO;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] gate(input logic [1:0] lane, input logic ok);
    if (lane == NO) return NO;
    if (ok && lane == ON) return ON;
    return ZE;
  endfunction

  // Returns {up, dn, lf, rt}
  function automatic logic [7:0] predict(input logic [2:0] k,
      input logic [1:0] u, input logic [1:0] d, input logic [1:0] l, input logic [1:0] r,
      input logic dr, input logic dl, input logic [3:0] nv);
    logic [1:0] uo, dout, lo, ro;
    logic vp, hp, hg;
    vp = (k == 3'd1) || (k == 3'd3) || (k >= 3'd4);
    hp = (k == 3'd1) || (k == 3'd2);
    hg = (k >= 3'd4);
    uo   = vp ? d : NO;
    dout = vp ? u : NO;
    ro = hp ? l : (hg ? gate(l, dr) : NO);
    lo = hp ? r : (hg ? gate(r, dl) : NO);
    if (nv[3]) uo = NO;
    if (nv[2]) dout = NO;
    if (nv[1]) lo = NO;
    if (nv[0]) ro = NO;
    return {uo, dout, lo, ro};
  endfunction

  function automatic string tag_of(input logic [2:0] k);
    if (k == 3'd0) return "R7";
    if (k <= 3'd3) return "R8";
    return "R9 R10 R11";
  endfunction

  // Vertical tokens first, then lane tokens; compare in the same step.
  task automatic apply(input logic [1:0] u, input logic [1:0] d, input logic [1:0] l,
                       input logic [1:0] r, input logic [3:0] nv, input string req);
    logic [7:0] e;
    @(negedge clk);
    up_i = u; dn_i = d;
    {nv_u, nv_d, nv_l, nv_r} = nv;
    #1;
    if (cln(lf_i) == NO) dr_m = pred(kind_m, cln(dn_i));
    if (cln(rt_i) == NO) dl_m = pred(kind_m, cln(dn_i));
    lf_i = l; rt_i = r;
    #1;
    if (cln(lf_i) == NO) dr_m = pred(kind_m, cln(dn_i));
    if (cln(rt_i) == NO) dl_m = pred(kind_m, cln(dn_i));
    #1;
    e = predict(kind_m, cln(u), cln(d), cln(l), cln(r), dr_m, dl_m, nv);
    chk({req, " up_o"}, {2'b00, up_o}, {2'b00, e[7:6]});
    chk({req, " dn_o"}, {2'b00, dn_o}, {2'b00, e[5:4]});
    chk({req, " lf_o"}, {2'b00, lf_o}, {2'b00, e[3:2]});
    chk({req, " rt_o"}, {2'b00, rt_o}, {2'b00, e[1:0]});
  endtask

  task automatic load_kind(input logic [2:0] code);
    @(negedge clk);
    lf_i = NO; rt_i = NO; up_i = NO; dn_i = NO;
    {nv_u, nv_d, nv_l, nv_r} = 4'b0000;
    rst_n = 1'b0;
    for (int i = 2; i >= 0; i--) begin
      cfg_si = code[i];
      @(negedge clk);
    end
    up_i = ON; dn_i = ZE; lf_i = ON; rt_i = ZE;
    #1;
    // R5: frozen cell drives no token
    chk("R5 frozen outputs", {up_o, dn_o} | {lf_o, rt_o}, 4'b0000);
    lf_i = NO; rt_i = NO; up_i = NO; dn_i = NO;
    #1;
    rst_n = 1'b1;
    kind_m = code;
    dr_m = pred(code, NO);
    dl_m = pred(code, NO);
    #1;
    // R6: unused-lane flags depend on the type alone
    chk("R6 void flags", {2'b00, h_void, v_void},
        {2'b00, (code == 3'd0 || code == 3'd3), (code == 3'd0 || code == 3'd2)});
  endtask

  initial begin
    logic [5:0] bits;
    logic [1:0] ro [4];
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; cfg_si = 1'b0;
    up_i = NO; dn_i = NO; lf_i = NO; rt_i = NO;
    {nv_u, nv_d, nv_l, nv_r} = 4'b0000;
    kind_m = 3'd0; dr_m = 1'b0; dl_m = 1'b0;
    repeat (2) @(negedge clk);
    up_i = ON; lf_i = ZE;
    #1;
    chk("R5 reset state", {up_o, dn_o} | {lf_o, rt_o}, 4'b0000);
    up_i = NO; lf_i = NO;

    // R2 R3: six bits shifted; cfg_so lags three edges
    bits = 6'b101100;
    for (int k = 0; k < 6; k++) begin
      cfg_si = bits[5-k];
      @(negedge clk);
      if (k >= 2) chk("R3 cfg_so delay", {3'b000, cfg_so}, {3'b000, bits[5-(k-2)]});
    end
    rst_n = 1'b1;
    kind_m = 3'b100;
    dr_m = pred(kind_m, NO); dl_m = pred(kind_m, NO);
    #1;
    chk("R2 R6 type 100 flags", {2'b00, h_void, v_void}, 4'b0000);

    // R4: edges while running change nothing
    for (int k = 0; k < 6; k++) begin
      cfg_si = k[0];
      @(negedge clk);
      #1;
      chk("R4 cfg_so held", {3'b000, cfg_so}, 4'b0001);
    end
    // R11 R10 compare-one: capture, hold across a vertical change, release
    apply(NO, ON, NO, NO, 4'b0000, "R11 setup");
    apply(NO, ON, ON, NO, 4'b0000, "R10 R11 hit one");
    apply(NO, ZE, ON, NO, 4'b0000, "R11 hold after dn change");
    apply(NO, ZE, NO, NO, 4'b0000, "R11 lane empty");
    apply(NO, ZE, ON, NO, 4'b0000, "R11 new decision");
    apply(NO, ZE, ZE, ON, 4'b0000, "R9 zero on lane");

    // Every type with directed patterns
    for (int c = 0; c < 8; c++) begin
      load_kind(c[2:0]);
      apply(ON, ZE, ON, ZE, 4'b0000, tag_of(c[2:0]));
      apply(ZE, ON, NO, NO, 4'b0000, tag_of(c[2:0]));
      apply(ZE, ON, ZE, ON, 4'b0000, tag_of(c[2:0]));
      apply(NO, NO, ON, ON, 4'b0000, tag_of(c[2:0]));
      apply(NO, NO, NO, NO, 4'b0000, tag_of(c[2:0]));
    end

    // R1: illegal code on inputs
    load_kind(3'd1);
    apply(IL, ON, IL, ZE, 4'b0000, "R1 illegal input");
    #1;
    chk("R1 rt_o from 11", {2'b00, rt_o}, 4'b0000);
    chk("R1 dn_o from 11", {2'b00, dn_o}, 4'b0000);
    // R12: neighbour masks
    apply(ON, ON, ON, ON, 4'b1010, "R12 mask u l");
    apply(ON, ON, ON, ON, 4'b0101, "R12 mask d r");
    apply(ZE, ZE, ZE, ZE, 4'b1111, "R12 mask all");

    // Random stimulus
    for (int t = 0; t < 600; t++) begin
      logic [3:0] nv;
      if (t % 30 == 0) load_kind(3'($urandom % 8));
      nv = (($urandom % 5) == 0) ? 4'($urandom) : 4'b0000;
      for (int s = 0; s < 4; s++) ro[s] = 2'($urandom % 4);
      if (($urandom % 3) == 0) begin ro[2] = NO; ro[3] = NO; end
      apply(ro[0], ro[1], ro[2], ro[3], nv, {tag_of(kind_m), " R1 R12 random"});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule